// File: doc/BRIEF.md
# AC-Capable Boundary-Scan Driver Chain

This block is a serial chain of boundary-scan output cells for pins that drive capacitively coupled links. Each cell holds a shift stage and an update latch. A pin multiplexer picks either the functional (mission) data or the test path. In the AC test modes, an XOR sits between the update latch and that multiplexer. One generator, shared by all cells, drives the other input of every XOR. When the generator output is high, every test-driven pin shows the inverse of its latched value. An edge on the pin can therefore cross the coupling capacitor even though the scan clock is slow.

The surrounding TAP logic supplies decoded state strobes (capture, shift, update, run-test/idle) and a 2-bit instruction code. The generator holds its output low in the DC test instruction. In the pulse instruction it produces a single pulse for each visit to run-test/idle. In the train instruction it toggles on every falling TCK edge spent in run-test/idle. On the receive side, a small edge-capture stage per pin turns rising-edge and falling-edge strobes from the receiver comparators into a level. The chain samples that level during capture.

Top module: `ac_bscan_drv`

## Requirements
- R1: Synchronous active-low reset clears every shift stage, update latch, captured receive bit and the AC test signal, so TDO reads 0 and test-driven pins read 0.
- R2: In shift state under a test instruction (code 1, 2 or 3), each rising TCK edge loads TDI into cell NPIN-1 and moves every cell into the next lower index. TDO shows cell 0, so the first of NPIN shifted bits ends in cell 0.
- R3: On the falling TCK edge in update state under a test instruction, every update latch takes the value of its shift stage.
- R4: Under code 1 (DC test), each pin equals its update latch.
- R5: Under code 0 (any non-test instruction), each pin equals its mission input and the AC test signal is 0.
- R6: Under code 0, capture, shift and update strobes leave the shift stages and update latches unchanged.
- R7: The AC test signal changes only on falling TCK edges. It becomes 0 at any falling edge taken outside run-test/idle, or under code 0 or code 1.
- R8: Under code 2 (single pulse), the AC test signal goes to 1 at the first falling edge in run-test/idle and stays 1 while that state lasts. It returns to 0 at the first falling edge after leaving.
- R9: Under code 3 (pulse train), the AC test signal inverts at every falling edge in run-test/idle, starting from 0, so it is 1 after odd counts of such edges.
- R10: Under code 2 or 3, each pin equals its update latch XOR the AC test signal.
- R11: On each rising TCK edge, a pin's captured receive bit becomes 1 on a rise strobe alone and 0 on a fall strobe alone. It holds when neither or both strobes are high.
- R12: In capture state under a test instruction, a rising TCK edge loads every shift stage from its captured receive bit. Capture takes priority over a concurrent shift strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial test data in |
| instr | input | 2 | Instruction code: 0 other, 1 DC test, 2 single pulse, 3 pulse train |
| st_capture | input | 1 | TAP in capture state |
| st_shift | input | 1 | TAP in shift state |
| st_update | input | 1 | TAP in update state |
| st_idle | input | 1 | TAP in run-test/idle |
| mission | input | NPIN | Functional data per pin |
| rx_rise | input | NPIN | Receiver rising-edge strobe per pin |
| rx_fall | input | NPIN | Receiver falling-edge strobe per pin |
| tdo | output | 1 | Serial test data out |
| pin | output | NPIN | Pin drive values |

## Verification
The bench loads all sixteen patterns of a four-pin chain under every test instruction. It reads back the previous pattern on TDO, so a reversed chain direction or an off-by-one shift count shows up as wrong serial data. In both AC modes it follows the pins across several falling edges inside run-test/idle and one edge after leaving. A generator that toggles in pulse mode, fails to toggle in train mode, or misses the return to zero would leave the pins inverted at the wrong time. Scan activity under the non-test code is checked afterwards through TDO and the DC pin values, which catches an ungated update or shift. Receive strobe patterns that include simultaneous rise and fall expose a wrong hold priority in the edge capture.

// File: rtl/acdrv_pkg.sv
`timescale 1ns/1ps
// Shared instruction encoding and decode helpers for the AC boundary-scan driver.
// Assumes the instruction register outside this block presents a 2-bit code.
package acdrv_pkg;

    typedef enum logic [1:0] {
        INS_OTHER = 2'd0,
        INS_DC    = 2'd1,
        INS_PULSE = 2'd2,
        INS_TRAIN = 2'd3
    } ins_e;

    // True when the data register of this chain is selected.
    function automatic logic is_test(input ins_e i);
        return i != INS_OTHER;
    endfunction

endpackage

// File: rtl/acdrv_tsig_gen.sv
`timescale 1ns/1ps
// Single AC test signal generator shared by every driver cell.
// Updates on the falling TCK edge; assumes st_idle is stable over a TCK period.
module acdrv_tsig_gen (
    input  logic       tck,
    input  logic       rst_n,
    input  logic [1:0] instr,
    input  logic       st_idle,
    output logic       ac_sig
);
    import acdrv_pkg::*;

    ins_e ins_w;
    assign ins_w = ins_e'(instr);

    // Pulse: high for the whole idle visit; train: toggle per idle edge; else low.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            ac_sig <= 1'b0;
        end else begin
            case (ins_w)
                INS_PULSE: ac_sig <= st_idle;
                INS_TRAIN: ac_sig <= st_idle ? ~ac_sig : 1'b0;
                default:   ac_sig <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/acdrv_rx_edge.sv
`timescale 1ns/1ps
// Receive-side edge capture: rebuilds a level from rise/fall strobes per pin.
// Assumes the comparator strobes are already synchronous to TCK.
module acdrv_rx_edge #(
    parameter int NPIN = 4
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic [NPIN-1:0] rise,
    input  logic [NPIN-1:0] fall,
    output logic [NPIN-1:0] cap
);
    for (genvar g = 0; g < NPIN; g++) begin : g_bit
        // Set on a lone rise, clear on a lone fall, hold otherwise.
        always_ff @(posedge tck) begin
            if (!rst_n) begin
                cap[g] <= 1'b0;
            end else if (rise[g] && !fall[g]) begin
                cap[g] <= 1'b1;
            end else if (fall[g] && !rise[g]) begin
                cap[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/acdrv_cell.sv
`timescale 1ns/1ps
// One boundary-scan output cell: capture/shift stage, falling-edge update latch,
// AC inversion stage and pin mux. Enables arrive pre-gated by the instruction.
module acdrv_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic test_mode,
    input  logic ser_in,
    input  logic cap_val,
    input  logic ac_sig,
    input  logic mission,
    output logic ser_out,
    output logic pin_out
);
    logic sr_q;
    logic upd_q;
    logic ac_bit;

    // Shift stage: capture wins over shift.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sr_q <= 1'b0;
        end else if (cap_en) begin
            sr_q <= cap_val;
        end else if (shift_en) begin
            sr_q <= ser_in;
        end
    end

    // Update latch loads on the falling edge so the pin changes mid-period.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
        end else if (upd_en) begin
            upd_q <= sr_q;
        end
    end

    // AC stage and pin select.
    always_comb begin
        ac_bit  = upd_q ^ ac_sig;
        pin_out = test_mode ? ac_bit : mission;
    end

    assign ser_out = sr_q;
endmodule

// File: rtl/ac_bscan_drv.sv
`timescale 1ns/1ps
// Top: chain of NPIN AC-capable driver cells, one shared AC test signal
// generator and the receive edge capture. TDI feeds cell NPIN-1, TDO is cell 0.
// Assumes decoded TAP state strobes that change after the rising TCK edge.
module ac_bscan_drv #(
    parameter int NPIN = 4
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic [1:0]      instr,
    input  logic            st_capture,
    input  logic            st_shift,
    input  logic            st_update,
    input  logic            st_idle,
    input  logic [NPIN-1:0] mission,
    input  logic [NPIN-1:0] rx_rise,
    input  logic [NPIN-1:0] rx_fall,
    output logic            tdo,
    output logic [NPIN-1:0] pin
);
    import acdrv_pkg::*;

    localparam int NLINK = NPIN + 1;

    logic             test_sel;
    logic             cap_en;
    logic             shift_en;
    logic             upd_en;
    logic             ac_sig;
    logic [NPIN-1:0]  rx_cap;
    logic [NLINK-1:0] link;

    // Gate data-register operations with the instruction decode.
    always_comb begin
        test_sel = is_test(ins_e'(instr));
        cap_en   = st_capture & test_sel;
        shift_en = st_shift & test_sel;
        upd_en   = st_update & test_sel;
    end

    acdrv_tsig_gen u_tsig (
        .tck     (tck),
        .rst_n   (rst_n),
        .instr   (instr),
        .st_idle (st_idle),
        .ac_sig  (ac_sig)
    );

    acdrv_rx_edge #(.NPIN(NPIN)) u_rx (
        .tck   (tck),
        .rst_n (rst_n),
        .rise  (rx_rise),
        .fall  (rx_fall),
        .cap   (rx_cap)
    );

    assign link[NPIN] = tdi;

    for (genvar g = 0; g < NPIN; g++) begin : g_cell
        acdrv_cell u_cell (
            .tck       (tck),
            .rst_n     (rst_n),
            .cap_en    (cap_en),
            .shift_en  (shift_en),
            .upd_en    (upd_en),
            .test_mode (test_sel),
            .ser_in    (link[g+1]),
            .cap_val   (rx_cap[g]),
            .ac_sig    (ac_sig),
            .mission   (mission[g]),
            .ser_out   (link[g]),
            .pin_out   (pin[g])
        );
    end

    assign tdo = link[0];
endmodule

// File: rtl/ac_bscan_drv_chk.sv
`timescale 1ns/1ps
// Checker for the AC test signal generator and receive capture, bound to the top.
module ac_bscan_drv_chk #(
    parameter int NPIN = 4
) (
    input logic            tck,
    input logic            rst_n,
    input logic [1:0]      instr,
    input logic            st_idle,
    input logic            ac_sig,
    input logic [NPIN-1:0] rx_rise,
    input logic [NPIN-1:0] rx_fall,
    input logic [NPIN-1:0] rx_cap
);
    import acdrv_pkg::*;

    AST_AC_LOW_OUTSIDE_IDLE: assert property (@(negedge tck) disable iff (!rst_n)
        !st_idle |=> !ac_sig); // R7
    AST_AC_LOW_NON_AC: assert property (@(negedge tck) disable iff (!rst_n)
        (instr == INS_OTHER || instr == INS_DC) |=> !ac_sig); // R7
    AST_PULSE_HIGH_IN_IDLE: assert property (@(negedge tck) disable iff (!rst_n)
        (instr == INS_PULSE && st_idle) |=> ac_sig); // R8
    AST_TRAIN_TOGGLES: assert property (@(negedge tck) disable iff (!rst_n)
        (instr == INS_TRAIN && st_idle) |=> (ac_sig != $past(ac_sig))); // R9

    for (genvar g = 0; g < NPIN; g++) begin : g_rx
        AST_RX_SET: assert property (@(posedge tck) disable iff (!rst_n)
            (rx_rise[g] && !rx_fall[g]) |=> rx_cap[g]); // R11
        AST_RX_CLEAR: assert property (@(posedge tck) disable iff (!rst_n)
            (rx_fall[g] && !rx_rise[g]) |=> !rx_cap[g]); // R11
        AST_RX_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
            (rx_rise[g] == rx_fall[g]) |=> $stable(rx_cap[g])); // R11
    end
endmodule

bind ac_bscan_drv ac_bscan_drv_chk #(.NPIN(NPIN)) u_chk (
    .tck     (tck),
    .rst_n   (rst_n),
    .instr   (instr),
    .st_idle (st_idle),
    .ac_sig  (ac_sig),
    .rx_rise (rx_rise),
    .rx_fall (rx_fall),
    .rx_cap  (rx_cap)
);

// File: tb/ac_bscan_drv_bench.sv
`timescale 1ns/1ps
module ac_bscan_drv_bench;
    localparam int N = 4;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tdi = 1'b0;
    logic [1:0]   instr = 2'd1;
    logic         st_capture = 1'b0;
    logic         st_shift = 1'b0;
    logic         st_update = 1'b0;
    logic         st_idle = 1'b0;
    logic [N-1:0] mission = '0;
    logic [N-1:0] rx_rise = '0;
    logic [N-1:0] rx_fall = '0;
    logic         tdo;
    logic [N-1:0] pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [N-1:0] prev = '0;
    logic [N-1:0] capm = '0;

    ac_bscan_drv #(.NPIN(N)) u_ac_bscan_drv (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .instr(instr),
        .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update),
        .st_idle(st_idle), .mission(mission), .rx_rise(rx_rise),
        .rx_fall(rx_fall), .tdo(tdo), .pin(pin)
    );

    always #2.5 tck = ~tck;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    // Shift vec in (bit 0 first) while checking the outgoing TDO sequence (R2).
    task automatic load(input logic [N-1:0] vec, input logic [N-1:0] exp_out);
        st_shift = 1'b1;
        for (int i = 0; i < N; i++) begin
            chk("R2 tdo", {31'd0, tdo}, {31'd0, exp_out[i]});
            tdi = vec[i];
            step();
        end
        st_shift = 1'b0;
        tdi = 1'b0;
    endtask

    // One cycle in update state; latch loads on the falling edge (R3).
    task automatic update();
        st_update = 1'b1;
        step();
        st_update = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 tdo", {31'd0, tdo}, 32'd0);
        chk("R1 pin", {28'd0, pin}, 32'd0);
        instr = 2'd0;
        mission = 4'hA;
        #1;
        chk("R5 mission", {28'd0, pin}, 32'hA);
        instr = 2'd1;
        st_capture = 1'b1;
        step();
        st_capture = 1'b0;
        load('0, '0); // R1: captured receive bits are 0 after reset

        // R3/R4: exhaustive DC update sweep
        for (int v = 0; v < 16; v++) begin
            load(v[N-1:0], prev);
            update();
            chk("R4 dc pin", {28'd0, pin}, v);
            prev = v[N-1:0];
        end

        // R5/R6: non-test code ignores scan operations
        instr = 2'd0;
        mission = 4'h5;
        #1;
        chk("R5 mission", {28'd0, pin}, 32'h5);
        load(~prev, {N{prev[0]}});
        rx_rise = '1;
        step();
        rx_rise = '0;
        capm = '1;
        st_capture = 1'b1;
        step();
        st_capture = 1'b0;
        update();
        chk("R5 mission held", {28'd0, pin}, 32'h5);
        instr = 2'd1;
        #1;
        chk("R6 latch kept", {28'd0, pin}, {28'd0, prev});
        load(prev, prev); // R6: shift stages kept

        // R7/R8/R9/R10: AC modes, all patterns
        for (int m = 2; m < 4; m++) begin
            instr = m[1:0];
            for (int v = 0; v < 16; v++) begin
                load(v[N-1:0], prev);
                update();
                prev = v[N-1:0];
                chk("R10 pin after update", {28'd0, pin}, v);
                st_idle = 1'b1;
                for (int k = 1; k <= 4; k++) begin
                    logic a;
                    @(negedge tck);
                    #1;
                    a = (m == 2) ? 1'b1 : logic'(k % 2);
                    if (k == 4) st_idle = 1'b0;
                    chk(m == 2 ? "R8 pulse" : "R9 train", {28'd0, pin},
                        {28'd0, prev ^ {N{a}}});
                end
                @(negedge tck);
                #1;
                chk("R7 idle exit", {28'd0, pin}, v);
                step();
            end
        end

        // R7: DC code stays static in idle
        instr = 2'd1;
        load(4'h9, prev);
        update();
        prev = 4'h9;
        st_idle = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge tck);
            #1;
            chk("R7 dc idle", {28'd0, pin}, 32'h9);
        end
        st_idle = 1'b0;
        step();

        // R11/R12: receive capture patterns, capture beats shift
        for (int p = 1; p < 9; p++) begin
            logic [N-1:0] r;
            logic [N-1:0] f;
            r = N'((p * 3) % 16);
            f = N'((p * 5) % 16);
            rx_rise = r;
            rx_fall = f;
            step();
            capm = (capm | (r & ~f)) & ~(f & ~r);
            rx_rise = '0;
            rx_fall = '0;
            st_capture = 1'b1;
            st_shift = 1'b1;
            tdi = 1'b1;
            step();
            st_capture = 1'b0;
            load('0, capm); // R11/R12 capture contents on TDO
            prev = '0;
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule